// File: doc/BRIEF.md
# DRAM Frequency Change Sequencer

This block steps a DDR4 memory subsystem from its present frequency set point to a new one (set points 0, 1 and 2). A single-cycle start pulse with a target set point begins the move. The sequencer first shuts off host traffic and holds off automatic ZQ calibration and refresh. It then waits for the read and write queues to drain. When needed, it issues termination and DLL mode-register writes. It puts the DRAM into self-refresh, runs the PHY re-initialisation and clock-switch handshakes, and waits out a programmable refresh guard interval. Finally it leaves self-refresh, rewrites the mode registers, restores calibration, refresh and traffic, and reports completion.

The route taken depends on set point 0. Set point 0 runs with the DRAM DLL on and the other set points run with it off. A move away from 0 switches the DLL off first, and a move into 0 switches it back on after the clock change. Any other move goes through self-refresh with only the final rewrite. The mode-register values for the target set point arrive as seven packed 16-bit fields. Each write goes out through a request/acknowledge port to a separate command issuer.

Top module: `dfc_sequencer`

## Requirements
- R1: The move is a DLL-off move when `cur_sp` is 0 and the target is not 0. On such a move, before `selfref_req` rises, the block issues the following writes, each for ranks 1 up to `num_ranks` in turn: MR1 with bits [10:8] cleared (skipped when those bits are already 0), MR5 with bits [8:6] cleared (skipped when 0), MR2 with bits [11:9] cleared (skipped when 0), and MR1 with bit 0 cleared (never skipped).
- R2: The move is a DLL-on move when `cur_sp` is not 0 and the target is 0. On such a move, after self-refresh exit and before the full rewrite, the block writes MR1 with bit 0 set to each rank, then MR0 with bit 8 set to each rank.
- R3: Any other move (including a move to the present set point) issues no mode-register write before self-refresh and only the full rewrite after it.
- R4: After self-refresh exit on every move, the block writes MRk = `mr_vals[16k+15:16k]` for k = 0 to 6, rank by rank from rank 1 up to `num_ranks`.
- R5: From the cycle after start is accepted, `host_en` is 0 and `zq_off` and `refresh_off` are 1. No mode-register write and no self-refresh request occurs until `rd_q_empty` and `wr_q_empty` are both 1.
- R6: `phy_init_start` is not raised before `op_status` reads 6'h23 (self-refresh entered by request). Mode-register writes after the clock change wait until `op_status` differs from 6'h23.
- R7: `phy_init_start` rises and the block waits for `phy_init_done` to fall. It then holds `clk_sw_req` with `clk_sw_sp` equal to the target until `clk_sw_ack`, drops `phy_init_start`, and waits for `phy_init_done` to rise. There is exactly one clock switch per move.
- R8: `selfref_req` stays 1 for exactly `guard_cycles`+1 cycles after the cycle in which the rise of `phy_init_done` is accepted.
- R9: `zq_off` and `refresh_off` drop one cycle before `host_en` returns to 1. `done` is a one-cycle pulse in the first cycle with `host_en` = 1, and in that cycle `cur_sp` already equals the target.
- R10: A start pulse while a move is in progress is ignored. The target of the running move does not change, and no second move follows.
- R11: After reset, `host_en` = 1, `cur_sp` = 0, and `zq_off`, `refresh_off`, `selfref_req`, `phy_init_start`, `clk_sw_req`, `mrw_req` and `done` are all 0.
- R12: `mrw_req` stays 1 with `mrw_rank`, `mrw_addr` and `mrw_data` unchanged until a cycle with `mrw_ack` = 1. Each acknowledged request is exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| target_sp | input | 2 | Target set point (0 to 2) |
| num_ranks | input | RW | Number of populated ranks, 1 to MAX_RANKS |
| guard_cycles | input | GUARD_W | Refresh guard interval in cycles |
| mr_vals | input | 112 | MR0 to MR6 for the target, MRk at bits [16k+15:16k] |
| rd_q_empty | input | 1 | Read queue empty |
| wr_q_empty | input | 1 | Write queue empty |
| op_status | input | 6 | Controller operating status, 6'h23 = software self-refresh |
| phy_init_done | input | 1 | PHY init complete |
| clk_sw_ack | input | 1 | Clock switch finished |
| mrw_ack | input | 1 | Mode-register write taken |
| host_en | output | 1 | Host traffic allowed |
| zq_off | output | 1 | Automatic ZQ calibration held off (all set points) |
| refresh_off | output | 1 | Automatic refresh held off |
| selfref_req | output | 1 | Self-refresh request |
| phy_init_start | output | 1 | PHY init start |
| clk_sw_req | output | 1 | Clock switch request |
| clk_sw_sp | output | 2 | Set point for the clock switch |
| mrw_req | output | 1 | Mode-register write request |
| mrw_rank | output | RW | Rank number, from 1 |
| mrw_addr | output | 3 | Mode register index |
| mrw_data | output | 16 | Mode register value |
| cur_sp | output | 2 | Current set point |
| done | output | 1 | Move complete pulse |

## Verification
The assertions assume well-behaved neighbours. `mr_vals`, `num_ranks` and `target_sp` stay stable while a move runs, apart from the ignored start. `num_ranks` lies in 1 to MAX_RANKS. `phy_init_done` stays low until `phy_init_start` drops. `op_status` reads 6'h23 only while self-refresh is requested. The bench builds its PHY, clock, status and command-issuer models to follow exactly these rules. It holds every input still during a move, except for the deliberate mid-move start pulse, which carries a different target.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  localparam int MR_COUNT = 7;
  localparam int MR_W     = 16;
  localparam int SP_W     = 2;
  localparam logic [5:0] SR_BY_SW = 6'h23;

  typedef enum logic [1:0] {PATH_SAME, PATH_DLL_OFF, PATH_DLL_ON} path_e;

  typedef enum logic [2:0] {
    OP_NOM, OP_PARK, OP_WR, OP_DLLOFF, OP_DLLON, OP_DLLRST, OP_ALL, OP_END
  } mr_op_e;

  function automatic path_e classify(input logic [SP_W-1:0] cur, input logic [SP_W-1:0] tgt);
    if (cur == '0 && tgt != '0)      return PATH_DLL_OFF;
    else if (cur != '0 && tgt == '0) return PATH_DLL_ON;
    else                             return PATH_SAME;
  endfunction

  function automatic mr_op_e first_pre(input path_e p);
    return (p == PATH_DLL_OFF) ? OP_NOM : OP_END;
  endfunction

  function automatic mr_op_e first_post(input path_e p);
    return (p == PATH_DLL_ON) ? OP_DLLON : OP_ALL;
  endfunction

  function automatic mr_op_e next_op(input mr_op_e op);
    case (op)
      OP_NOM:    return OP_PARK;
      OP_PARK:   return OP_WR;
      OP_WR:     return OP_DLLOFF;
      OP_DLLON:  return OP_DLLRST;
      OP_DLLRST: return OP_ALL;
      default:   return OP_END;
    endcase
  endfunction

  function automatic logic [2:0] op_addr(input mr_op_e op, input logic [2:0] idx);
    case (op)
      OP_NOM, OP_DLLOFF, OP_DLLON: return 3'd1;
      OP_PARK:   return 3'd5;
      OP_WR:     return 3'd2;
      OP_ALL:    return idx;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [MR_W-1:0] op_data(input mr_op_e op, input logic [MR_W-1:0] base);
    case (op)
      OP_NOM:    return base & ~16'h0700;
      OP_PARK:   return base & ~16'h01C0;
      OP_WR:     return base & ~16'h0E00;
      OP_DLLOFF: return base & ~16'h0001;
      OP_DLLON:  return base | 16'h0001;
      OP_DLLRST: return base | 16'h0100;
      default:   return base;
    endcase
  endfunction

  function automatic logic op_skip(input mr_op_e op, input logic [MR_W-1:0] base);
    case (op)
      OP_NOM:  return base[10:8] == 3'd0;
      OP_PARK: return base[8:6]  == 3'd0;
      OP_WR:   return base[11:9] == 3'd0;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dfc_guard_timer.sv
module dfc_guard_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] cycles,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= cycles;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dfc_mr_stepper.sv
module dfc_mr_stepper
  import dfc_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  parameter int RW        = $clog2(MAX_RANKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  mr_op_e                   op,
  input  logic [RW-1:0]            num_ranks,
  input  logic [MR_COUNT*MR_W-1:0] mr_vals,
  input  logic                     mrw_ack,
  output logic                     mrw_req,
  output logic [RW-1:0]            mrw_rank,
  output logic [2:0]               mrw_addr,
  output logic [MR_W-1:0]          mrw_data,
  output logic                     fin
);
  logic [MR_W-1:0] mr_arr [MR_COUNT];
  logic            busy;
  logic [RW-1:0]   rank;
  logic [2:0]      mri;
  logic [MR_W-1:0] base;
  logic            skip_now;
  logic            last_mr;

  for (genvar k = 0; k < MR_COUNT; k++) begin : g_mr
    assign mr_arr[k] = mr_vals[k*MR_W +: MR_W];
  end

  assign mrw_addr = op_addr(op, mri);
  assign base     = mr_arr[mrw_addr];
  assign mrw_data = op_data(op, base);
  assign skip_now = op_skip(op, base);
  assign mrw_rank = rank;
  assign last_mr  = (op != OP_ALL) || (mri == 3'(MR_COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rank    <= RW'(1);
      mri     <= '0;
      mrw_req <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        rank    <= RW'(1);
        mri     <= '0;
        mrw_req <= 1'b0;
      end else if (busy) begin
        if (!mrw_req) begin
          if (skip_now) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            mrw_req <= 1'b1;
          end
        end else if (mrw_ack) begin
          mrw_req <= 1'b0;
          if (!last_mr) begin
            mri <= mri + 3'd1;
          end else begin
            mri <= '0;
            if (rank >= num_ranks) begin
              busy <= 1'b0;
              fin  <= 1'b1;
            end else begin
              rank <= rank + RW'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dfc_sequencer.sv
module dfc_sequencer
  import dfc_pkg::*;
#(
  parameter int MAX_RANKS = 2,
  parameter int GUARD_W   = 16,
  localparam int RW       = $clog2(MAX_RANKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               target_sp,
  input  logic [RW-1:0]            num_ranks,
  input  logic [GUARD_W-1:0]       guard_cycles,
  input  logic [MR_COUNT*MR_W-1:0] mr_vals,
  input  logic                     rd_q_empty,
  input  logic                     wr_q_empty,
  input  logic [5:0]               op_status,
  input  logic                     phy_init_done,
  input  logic                     clk_sw_ack,
  input  logic                     mrw_ack,
  output logic                     host_en,
  output logic                     zq_off,
  output logic                     refresh_off,
  output logic                     selfref_req,
  output logic                     phy_init_start,
  output logic                     clk_sw_req,
  output logic [1:0]               clk_sw_sp,
  output logic                     mrw_req,
  output logic [RW-1:0]            mrw_rank,
  output logic [2:0]               mrw_addr,
  output logic [MR_W-1:0]          mrw_data,
  output logic [1:0]               cur_sp,
  output logic                     done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_QUIESCE, ST_DRAIN, ST_PRE_MR, ST_SR_IN, ST_PHY_LO, ST_CLK,
    ST_PHY_HI, ST_GUARD, ST_SR_OUT, ST_POST_MR, ST_RESTORE, ST_DONE
  } state_e;

  state_e     state;
  path_e      path_q;
  mr_op_e     op_q;
  mr_op_e     op_nxt;
  logic [1:0] tgt_q;
  logic       go_q;

  // named internal events
  logic ev_idle, ev_accept, ev_drained, ev_guard_start, ev_guard_done, step_fin;

  assign ev_idle        = (state == ST_IDLE);
  assign ev_accept      = ev_idle && start;
  assign ev_drained     = (state == ST_DRAIN) && rd_q_empty && wr_q_empty;
  assign ev_guard_start = (state == ST_PHY_HI) && phy_init_done;
  assign op_nxt         = next_op(op_q);

  dfc_guard_timer #(.W(GUARD_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_guard_start),
    .cycles  (guard_cycles),
    .expired (ev_guard_done)
  );

  dfc_mr_stepper #(.MAX_RANKS(MAX_RANKS), .RW(RW)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .op        (op_q),
    .num_ranks (num_ranks),
    .mr_vals   (mr_vals),
    .mrw_ack   (mrw_ack),
    .mrw_req   (mrw_req),
    .mrw_rank  (mrw_rank),
    .mrw_addr  (mrw_addr),
    .mrw_data  (mrw_data),
    .fin       (step_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      path_q <= PATH_SAME;
      op_q   <= OP_END;
      tgt_q  <= '0;
      cur_sp <= '0;
      go_q   <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          tgt_q  <= target_sp;
          path_q <= classify(cur_sp, target_sp);
          state  <= ST_QUIESCE;
        end
        ST_QUIESCE: state <= ST_DRAIN;
        ST_DRAIN: if (ev_drained) begin
          op_q <= first_pre(path_q);
          if (first_pre(path_q) == OP_END) state <= ST_SR_IN;
          else begin
            go_q  <= 1'b1;
            state <= ST_PRE_MR;
          end
        end
        ST_PRE_MR: if (step_fin) begin
          op_q <= op_nxt;
          if (op_nxt == OP_END) state <= ST_SR_IN;
          else go_q <= 1'b1;
        end
        ST_SR_IN:  if (op_status == SR_BY_SW) state <= ST_PHY_LO;
        ST_PHY_LO: if (!phy_init_done) state <= ST_CLK;
        ST_CLK:    if (clk_sw_ack) state <= ST_PHY_HI;
        ST_PHY_HI: if (phy_init_done) state <= ST_GUARD;
        ST_GUARD:  if (ev_guard_done) state <= ST_SR_OUT;
        ST_SR_OUT: if (op_status != SR_BY_SW) begin
          op_q  <= first_post(path_q);
          go_q  <= 1'b1;
          state <= ST_POST_MR;
        end
        ST_POST_MR: if (step_fin) begin
          op_q <= op_nxt;
          if (op_nxt == OP_END) state <= ST_RESTORE;
          else go_q <= 1'b1;
        end
        ST_RESTORE: begin
          cur_sp <= tgt_q;
          state  <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_en        = ev_idle || (state == ST_DONE);
  assign zq_off         = !(ev_idle || state == ST_RESTORE || state == ST_DONE);
  assign refresh_off    = zq_off;
  assign selfref_req    = (state == ST_SR_IN) || (state == ST_PHY_LO) || (state == ST_CLK) ||
                          (state == ST_PHY_HI) || (state == ST_GUARD);
  assign phy_init_start = (state == ST_PHY_LO) || (state == ST_CLK);
  assign clk_sw_req     = (state == ST_CLK);
  assign clk_sw_sp      = tgt_q;
  assign done           = (state == ST_DONE);
endmodule

// File: rtl/dfc_sequencer_chk.sv
module dfc_sequencer_chk #(
  parameter int RW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_en,
  input logic          zq_off,
  input logic          refresh_off,
  input logic          selfref_req,
  input logic          phy_init_start,
  input logic          phy_init_done,
  input logic          clk_sw_req,
  input logic [1:0]    clk_sw_sp,
  input logic          mrw_req,
  input logic          mrw_ack,
  input logic [RW-1:0] mrw_rank,
  input logic [2:0]    mrw_addr,
  input logic [15:0]   mrw_data,
  input logic [RW-1:0] num_ranks,
  input logic [5:0]    op_status,
  input logic [1:0]    cur_sp,
  input logic          done,
  input logic          ev_idle
);
  assert_mrw_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mrw_req |-> (!host_en && zq_off && refresh_off));

  assert_sr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    selfref_req |-> (!host_en && zq_off && refresh_off));

  assert_phy_in_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_init_start |-> selfref_req);

  assert_phy_after_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_init_start) |-> ($past(op_status) == 6'h23));

  assert_clk_in_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req |-> (phy_init_start && !phy_init_done));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (host_en && !zq_off && cur_sp == clk_sw_sp));

  assert_target_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_idle |=> $stable(clk_sw_sp));

  assert_sp_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sp != 2'd3);

  assert_mrw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrw_req && !mrw_ack) |=> (mrw_req && $stable(mrw_addr) && $stable(mrw_data) && $stable(mrw_rank)));

  assert_mrw_rank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mrw_req |-> (mrw_rank != '0 && mrw_rank <= num_ranks));
endmodule

bind dfc_sequencer dfc_sequencer_chk #(.RW(RW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_en        (host_en),
  .zq_off         (zq_off),
  .refresh_off    (refresh_off),
  .selfref_req    (selfref_req),
  .phy_init_start (phy_init_start),
  .phy_init_done  (phy_init_done),
  .clk_sw_req     (clk_sw_req),
  .clk_sw_sp      (clk_sw_sp),
  .mrw_req        (mrw_req),
  .mrw_ack        (mrw_ack),
  .mrw_rank       (mrw_rank),
  .mrw_addr       (mrw_addr),
  .mrw_data       (mrw_data),
  .num_ranks      (num_ranks),
  .op_status      (op_status),
  .cur_sp         (cur_sp),
  .done           (done),
  .ev_idle        (ev_idle)
);

// File: tb/dfc_sequencer_test.sv
`timescale 1ns/1ps
module dfc_sequencer_test;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [1:0]    target_sp = '0;
  logic [RW-1:0] num_ranks = RW'(1);
  logic [15:0]   guard_cycles = '0;
  logic [111:0]  mr_vals = '0;
  logic          rd_q_empty = 1'b1, wr_q_empty = 1'b1;
  logic [5:0]    op_status;
  logic          phy_init_done, clk_sw_ack, mrw_ack;
  logic          host_en, zq_off, refresh_off, selfref_req, phy_init_start, clk_sw_req;
  logic [1:0]    clk_sw_sp, cur_sp;
  logic          mrw_req, done;
  logic [RW-1:0] mrw_rank;
  logic [2:0]    mrw_addr;
  logic [15:0]   mrw_data;

  dfc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_sp(target_sp), .num_ranks(num_ranks),
    .guard_cycles(guard_cycles), .mr_vals(mr_vals), .rd_q_empty(rd_q_empty),
    .wr_q_empty(wr_q_empty), .op_status(op_status), .phy_init_done(phy_init_done),
    .clk_sw_ack(clk_sw_ack), .mrw_ack(mrw_ack), .host_en(host_en), .zq_off(zq_off),
    .refresh_off(refresh_off), .selfref_req(selfref_req), .phy_init_start(phy_init_start),
    .clk_sw_req(clk_sw_req), .clk_sw_sp(clk_sw_sp), .mrw_req(mrw_req), .mrw_rank(mrw_rank),
    .mrw_addr(mrw_addr), .mrw_data(mrw_data), .cur_sp(cur_sp), .done(done)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- neighbour models and monitor ----------------
  int log_n = 0, clk_n = 0, guard_acc = 0, v_r6 = 0, v_r7 = 0, v_r12 = 0;
  int log_rank [2048], log_addr [2048], log_data [2048], log_clk [2048];
  int exp_tgt = 0;
  int sts_cnt = 0, phy_cnt = 0, clk_cnt = 0;
  bit phy_low_seen = 0;
  logic p_req = 0;
  logic [2:0] p_addr = 0;
  logic [15:0] p_data = 0;
  logic [RW-1:0] p_rank = 0;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_status <= 6'h01; phy_init_done <= 1'b1; clk_sw_ack <= 1'b0; mrw_ack <= 1'b0;
      sts_cnt = 0; phy_cnt = 0; clk_cnt = 0; p_req <= 1'b0; phy_low_seen = 0;
    end else begin
      // command issuer: acknowledge and log each request
      if (mrw_req && !mrw_ack) begin
        mrw_ack <= 1'b1;
        log_rank[log_n % 2048] = int'(mrw_rank);
        log_addr[log_n % 2048] = int'(mrw_addr);
        log_data[log_n % 2048] = int'(mrw_data);
        log_clk[log_n % 2048]  = clk_n;
        log_n++;
      end else mrw_ack <= 1'b0;
      // R12 monitor: request may only change after an acknowledge
      if (p_req && !mrw_ack && (!mrw_req || mrw_addr != p_addr || mrw_data != p_data || mrw_rank != p_rank))
        v_r12++;
      p_req <= mrw_req; p_addr <= mrw_addr; p_data <= mrw_data; p_rank <= mrw_rank;
      // status model
      if (selfref_req && op_status != 6'h23) begin
        sts_cnt++; if (sts_cnt >= 2) begin op_status <= 6'h23; sts_cnt = 0; end
      end else if (!selfref_req && op_status == 6'h23) begin
        sts_cnt++; if (sts_cnt >= 2) begin op_status <= 6'h01; sts_cnt = 0; end
      end else sts_cnt = 0;
      // PHY model
      if (phy_init_start && phy_init_done) begin
        phy_cnt++; if (phy_cnt >= 2) begin phy_init_done <= 1'b0; phy_cnt = 0; end
      end else if (!phy_init_start && !phy_init_done) begin
        phy_cnt++; if (phy_cnt >= 3) begin phy_init_done <= 1'b1; phy_cnt = 0; end
      end else phy_cnt = 0;
      // clock switch model
      if (clk_sw_req && !clk_sw_ack) begin
        clk_cnt++; if (clk_cnt >= 2) begin clk_sw_ack <= 1'b1; clk_n++; clk_cnt = 0; end
      end else clk_sw_ack <= 1'b0;
      // R6 / R7 monitors
      if (phy_init_start && op_status != 6'h23) v_r6++;
      if (mrw_req && op_status == 6'h23) v_r6++;
      if (clk_sw_req && (phy_init_done || clk_sw_sp != 2'(exp_tgt))) v_r7++;
      // R8 guard measurement
      if (!phy_init_done) phy_low_seen = 1;
      if (phy_low_seen && phy_init_done && selfref_req) guard_acc++;
      if (!selfref_req) phy_low_seen = 0;
    end
  end

  // ---------------- expected values ----------------
  int e_n;
  int e_rank [64], e_addr [64], e_data [64], e_post [64];
  string e_req [64];

  function automatic int mk_mr(input int seed, input int k, input bit zero_rtt);
    int v;
    v = ((16'h1111 * k) ^ (seed * 16'h2357)) & 16'hFFFF;
    if (zero_rtt) v = v & 16'hF03F; else v = v | 16'h0100;
    return v;
  endfunction

  task automatic add_exp(input int r, input int a, input int d, input int post, input string req);
    e_rank[e_n] = r; e_addr[e_n] = a; e_data[e_n] = d; e_post[e_n] = post; e_req[e_n] = req;
    e_n++;
  endtask

  int cur_exp = 0;

  task automatic move(input int tgt, input int nr, input int seed, input bit zero_rtt,
                      input int gcyc, input int drain);
    int mr [7];
    int l0, c0, g0, a6, a7, a12;
    bit off_p, on_p, ok, got, pulsed;
    logic p_host, p_zq;
    string preq;
    for (int k = 0; k < 7; k++) mr[k] = mk_mr(seed, k, zero_rtt);
    off_p = (cur_exp == 0 && tgt != 0);
    on_p  = (cur_exp != 0 && tgt == 0);
    preq  = off_p ? "R1" : "R3";
    e_n = 0;
    if (off_p) begin
      if ((mr[1] & 16'h0700) != 0) for (int r = 1; r <= nr; r++) add_exp(r, 1, mr[1] & 16'hF8FF, 0, "R1");
      if ((mr[5] & 16'h01C0) != 0) for (int r = 1; r <= nr; r++) add_exp(r, 5, mr[5] & 16'hFE3F, 0, "R1");
      if ((mr[2] & 16'h0E00) != 0) for (int r = 1; r <= nr; r++) add_exp(r, 2, mr[2] & 16'hF1FF, 0, "R1");
      for (int r = 1; r <= nr; r++) add_exp(r, 1, mr[1] & 16'hFFFE, 0, "R1");
    end
    if (on_p) begin
      for (int r = 1; r <= nr; r++) add_exp(r, 1, mr[1] | 16'h0001, 1, "R2");
      for (int r = 1; r <= nr; r++) add_exp(r, 0, mr[0] | 16'h0100, 1, "R2");
    end
    for (int r = 1; r <= nr; r++)
      for (int k = 0; k < 7; k++) add_exp(r, k, mr[k], 1, "R4");

    l0 = log_n; c0 = clk_n; g0 = guard_acc; a6 = v_r6; a7 = v_r7; a12 = v_r12;
    @(negedge clk);
    exp_tgt = tgt;
    target_sp = 2'(tgt); num_ranks = RW'(nr); guard_cycles = 16'(gcyc);
    for (int k = 0; k < 7; k++) mr_vals[16*k +: 16] = 16'(mr[k]);
    rd_q_empty = (drain == 0); wr_q_empty = (drain == 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ok = 1;
    for (int i = 0; i < drain; i++) begin
      if (host_en || !zq_off || !refresh_off || mrw_req || selfref_req) ok = 0;
      if (i == drain - 1) rd_q_empty = 1'b1;
      @(negedge clk);
    end
    wr_q_empty = 1'b1;
    if (drain > 0) check(ok, "R5", "quiet while queues busy", ok, 1);
    else check(!host_en && zq_off && refresh_off, "R5", "host_en/zq_off/refresh_off after start",
               {host_en, zq_off, refresh_off}, 3'b011);

    got = 0; pulsed = 0; p_host = host_en; p_zq = zq_off;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (start) begin start = 1'b0; target_sp = 2'(tgt); end
      if (done) begin got = 1; break; end
      if (!pulsed && selfref_req) begin start = 1'b1; target_sp = 2'((tgt + 1) % 3); pulsed = 1; end
      p_host = host_en; p_zq = zq_off;
    end
    check(got, "R9", "done reached", got, 1);
    check(host_en && !zq_off && !refresh_off, "R9", "state at done",
          {host_en, zq_off, refresh_off}, 3'b100);
    check(cur_sp == 2'(tgt), "R9", "cur_sp at done", cur_sp, tgt);
    check(!p_host && !p_zq, "R9", "zq back one cycle before host", {p_host, p_zq}, 0);
    check(log_n - l0 == e_n, preq, "mode-register write count", log_n - l0, e_n);
    for (int i = 0; i < e_n && i < log_n - l0; i++) begin
      int j;
      j = (l0 + i) % 2048;
      check(log_rank[j] == e_rank[i] && log_addr[j] == e_addr[i] && log_data[j] == e_data[i] &&
            (log_clk[j] - c0) == e_post[i],
            e_post[i] == 0 ? e_req[i] : e_req[i], "mode-register write",
            (log_clk[j] - c0) * 64'h1000000 + log_rank[j] * 64'h100000 + log_addr[j] * 64'h10000 + log_data[j],
            e_post[i] * 64'h1000000 + e_rank[i] * 64'h100000 + e_addr[i] * 64'h10000 + e_data[i]);
    end
    check(clk_n - c0 == 1, "R7", "clock switches per move", clk_n - c0, 1);
    check(v_r7 == a7, "R7", "clock request order/target", v_r7 - a7, 0);
    check(v_r6 == a6, "R6", "status ordering", v_r6 - a6, 0);
    check(v_r12 == a12, "R12", "request held until ack", v_r12 - a12, 0);
    check(guard_acc - g0 == gcyc + 1, "R8", "guard cycles", guard_acc - g0, gcyc + 1);
    @(negedge clk);
    check(!done, "R9", "done one cycle", done, 0);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || !host_en || selfref_req) ok = 0;
    end
    check(ok && cur_sp == 2'(tgt), "R10", "mid-move start ignored", cur_sp, tgt);
    cur_exp = tgt;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_en && !zq_off && !refresh_off && !selfref_req && !phy_init_start &&
          !clk_sw_req && !mrw_req && !done && cur_sp == 0, "R11", "reset state",
          {host_en, zq_off, refresh_off, selfref_req, phy_init_start, clk_sw_req, mrw_req, done},
          8'b1000_0000);
    n = 0;
    for (int nr = 1; nr <= 2; nr++)
      for (int from = 0; from < 3; from++)
        for (int to = 0; to < 3; to++) begin
          if (cur_exp != from) begin
            move(from, nr, n + 7, n % 2 == 0, n % 3, 0);
            n++;
          end
          move(to, nr, n + 3, n % 3 == 2, (from + 2 * to + nr) % 5, to * 3);
          n++;
        end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule